// File: doc/BRIEF.md
# Seven-Bit Sync-Coded Serial Video Transmitter

This block turns a stream of pixel words into three single-bit serial lanes. Every seven clocks it sends one symbol: a 7-bit sync code on the sync lane and one pixel split over two data lanes. Each symbol is shifted out most significant bit first. A word strobe marks the first bit of every symbol. A receiver recovers frame and line timing from the sync code alone, so there are no separate valid wires.

The timing source gives a frame-start request, a pixel-valid flag, an output enable and the pixel word. The block samples these once per symbol. It sends the frame-start code and then holds three filler symbols, so the first pixel can only fall four symbols after the frame-start symbol. Every line has the same number of symbols, and pixel-valid counts only inside the line's active window. A frame has a fixed number of lines. After the last line the block goes idle until the next frame-start request. Dropping the enable blanks all three lanes for that symbol, and the internal timing keeps advancing.

Top module: `sync7_video_tx`

## Requirements
- R1: While rst_ni is low, every output is 0. The first word strobe comes in the first cycle after the first rising clock edge with rst_ni high.
- R2: A symbol lasts exactly 7 clocks. wstrb_o is high only in a symbol's first cycle, and that cycle carries the symbol's bit 6 (MSB first).
- R3: The sync lane carries 7'b1110000 for frame start, 7'b1100100 for a valid pixel, 7'b1100000 for no data, or all zeros while blanked.
- R4: In a valid-pixel symbol, lane_lo_o carries pix_i[6:0] and lane_hi_o carries pix_i[13:7], both MSB first. Widths below 14 are zero-extended.
- R5: In every symbol whose sync code is not the valid-pixel code, both data lanes are 0.
- R6: When sof_i is sampled high, the next symbol is the frame-start code. The 3 symbols after it are no-data whatever lv_i is. The fourth symbol after it is the first slot of line 0.
- R7: A line is LINE_SYMS symbols long. lv_i is honoured only in its first ACT_SYMS slots; the remaining slots are no-data.
- R8: A frame ends after LINES lines. Outside a frame, lv_i is ignored and no-data is sent.
- R9: sof_i sampled high during a frame restarts the frame-start sequence at once.
- R10: When en_i is sampled low, all three lanes are 0 for the resulting symbol. The symbol and line counters advance as if it had been sent.
- R11: Inputs are sampled at the rising edge that ends a symbol's last bit. Their result is the symbol that starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame-start request |
| lv_i | input | 1 | Pixel valid for this symbol slot |
| en_i | input | 1 | Output enable; low blanks the symbol |
| pix_i | input | PIX_W | Pixel word |
| sync_o | output | 1 | Sync code lane |
| lane_lo_o | output | 1 | Lower pixel half lane |
| lane_hi_o | output | 1 | Upper pixel half lane |
| wstrb_o | output | 1 | High on the first bit of each symbol |

## Verification
Inputs take effect one whole symbol late. The values present at the edge that closes bit 6 set the next symbol, whose MSB and strobe appear in the cycle right after that edge; the other six bits follow one per cycle. The bench drives new inputs at the falling edge in a symbol's strobe cycle. At the same time it computes the expected content of the current symbol from the inputs it drove one symbol earlier. It then compares the strobe and all three lanes at each of the seven following falling edges. The frame-start lead, the line window, the frame end, blanking and restart are all checked through this one-symbol offset.

// File: rtl/sync7_pkg.sv
package sync7_pkg;
  localparam int SYM_BITS  = 7;
  localparam int NUM_LANES = 3;

  typedef logic [SYM_BITS-1:0] sym_t;

  localparam sym_t CODE_FS = 7'b1110000;
  localparam sym_t CODE_PV = 7'b1100100;
  localparam sym_t CODE_NV = 7'b1100000;

  typedef enum logic [1:0] {
    FRM_IDLE,
    FRM_LEAD,
    FRM_LINE
  } frm_state_e;
endpackage

// File: rtl/sync7_bit_timer.sv
module sync7_bit_timer #(
  parameter int SYM_BITS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ld_o,
  output logic first_o
);
  localparam int CNT_W = $clog2(SYM_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset to the last bit so the first edge out of reset loads a symbol
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign ld_o    = (cnt_q == LAST);
  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/sync7_framer.sv
module sync7_framer
  import sync7_pkg::*;
#(
  parameter int PIX_W     = 14,
  parameter int LINE_SYMS = 12,
  parameter int ACT_SYMS  = 8,
  parameter int LINES     = 3,
  parameter int LEAD_SYMS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             sof_i,
  input  logic             lv_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] pix_i,
  output sym_t             sync_sym_o,
  output sym_t             lo_sym_o,
  output sym_t             hi_sym_o
);
  localparam int POS_W = (LINE_SYMS > 1) ? $clog2(LINE_SYMS) : 1;
  localparam int LN_W  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int LD_W  = (LEAD_SYMS > 1) ? $clog2(LEAD_SYMS) : 1;
  localparam int PAD_W = 2 * SYM_BITS;

  frm_state_e       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [LN_W-1:0]  line_q, line_d;
  logic [LD_W-1:0]  lead_q, lead_d;
  logic             take;
  sym_t             code;
  logic [PAD_W-1:0] pix_pad;

  always_comb begin
    pix_pad = '0;
    pix_pad[PIX_W-1:0] = pix_i;
  end

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    line_d = line_q;
    lead_d = lead_q;
    take   = 1'b0;
    code   = CODE_NV;
    if (sof_i) begin
      code   = CODE_FS;
      pos_d  = '0;
      line_d = '0;
      if (LEAD_SYMS > 1) begin
        st_d   = FRM_LEAD;
        lead_d = LD_W'(LEAD_SYMS - 1);
      end else begin
        st_d = FRM_LINE;
      end
    end else begin
      case (st_q)
        FRM_LEAD: begin
          lead_d = lead_q - LD_W'(1);
          if (lead_q == LD_W'(1)) st_d = FRM_LINE;
        end
        FRM_LINE: begin
          take = lv_i && ({1'b0, pos_q} < (POS_W + 1)'(ACT_SYMS));
          if (take) code = CODE_PV;
          if (pos_q == POS_W'(LINE_SYMS - 1)) begin
            pos_d = '0;
            if (line_q == LN_W'(LINES - 1)) begin
              st_d   = FRM_IDLE;
              line_d = '0;
            end else begin
              line_d = line_q + LN_W'(1);
            end
          end else begin
            pos_d = pos_q + POS_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FRM_IDLE;
      pos_q  <= '0;
      line_q <= '0;
      lead_q <= '0;
    end else if (ld_i) begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      line_q <= line_d;
      lead_q <= lead_d;
    end
  end

  assign sync_sym_o = en_i ? code : '0;
  assign lo_sym_o   = (en_i && take) ? pix_pad[SYM_BITS-1:0] : '0;
  assign hi_sym_o   = (en_i && take) ? pix_pad[PAD_W-1:SYM_BITS] : '0;
endmodule

// File: rtl/sync7_lane_ser.sv
module sync7_lane_ser #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] sym_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (ld_i) sh_q <= sym_i;
    else           sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_o = sh_q[W-1];
endmodule

// File: rtl/sync7_video_tx.sv
module sync7_video_tx
  import sync7_pkg::*;
#(
  parameter int PIX_W     = 14,
  parameter int LINE_SYMS = 12,
  parameter int ACT_SYMS  = 8,
  parameter int LINES     = 3,
  parameter int LEAD_SYMS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             lv_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             sync_o,
  output logic             lane_lo_o,
  output logic             lane_hi_o,
  output logic             wstrb_o
);
  logic                 sym_ld;
  logic                 sym_first;
  sym_t [NUM_LANES-1:0] lane_sym;
  logic [NUM_LANES-1:0] lane_bit;

  sync7_bit_timer #(.SYM_BITS(SYM_BITS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_o    (sym_ld),
    .first_o (sym_first)
  );

  sync7_framer #(
    .PIX_W     (PIX_W),
    .LINE_SYMS (LINE_SYMS),
    .ACT_SYMS  (ACT_SYMS),
    .LINES     (LINES),
    .LEAD_SYMS (LEAD_SYMS)
  ) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (sym_ld),
    .sof_i      (sof_i),
    .lv_i       (lv_i),
    .en_i       (en_i),
    .pix_i      (pix_i),
    .sync_sym_o (lane_sym[0]),
    .lo_sym_o   (lane_sym[1]),
    .hi_sym_o   (lane_sym[2])
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sync7_lane_ser #(.W(SYM_BITS)) u_ser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (sym_ld),
      .sym_i  (lane_sym[g]),
      .bit_o  (lane_bit[g])
    );
  end

  assign sync_o    = lane_bit[0];
  assign lane_lo_o = lane_bit[1];
  assign lane_hi_o = lane_bit[2];
  assign wstrb_o   = sym_first;
endmodule

// File: rtl/sync7_video_tx_chk.sv
module sync7_video_tx_chk
  import sync7_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic ld_i,
  input logic en_i,
  input logic wstrb_i,
  input logic sync_i,
  input logic lo_i,
  input logic hi_i
);
  logic [3:0] since_q;
  logic       seen_q;
  sym_t       sh_sync, sh_lo, sh_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      sh_sync <= '0;
      sh_lo   <= '0;
      sh_hi   <= '0;
    end else begin
      sh_sync <= {sh_sync[SYM_BITS-2:0], sync_i};
      sh_lo   <= {sh_lo[SYM_BITS-2:0], lo_i};
      sh_hi   <= {sh_hi[SYM_BITS-2:0], hi_i};
      if (wstrb_i) begin
        seen_q  <= 1'b1;
        since_q <= 4'd1;
      end else if (since_q != 4'hF) begin
        since_q <= since_q + 4'd1;
      end
    end
  end

  assert_strobe_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (wstrb_i == (since_q == 4'd7)));

  assert_sync_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && wstrb_i) |->
      (sh_sync == CODE_FS || sh_sync == CODE_PV || sh_sync == CODE_NV || sh_sync == '0));

  assert_data_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && wstrb_i && sh_sync != CODE_PV) |-> (sh_lo == '0 && sh_hi == '0));

  assert_blank_lanes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !en_i) |=> (!sync_i && !lo_i && !hi_i));
endmodule

bind sync7_video_tx sync7_video_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ld_i    (sym_ld),
  .en_i    (en_i),
  .wstrb_i (wstrb_o),
  .sync_i  (sync_o),
  .lo_i    (lane_lo_o),
  .hi_i    (lane_hi_o)
);

// File: tb/sync7_video_tx_tb.sv
module sync7_video_tx_tb;
  localparam int LSYM = 12;
  localparam int ACT  = 8;
  localparam int NL   = 3;
  localparam logic [6:0] FS = 7'b1110000;
  localparam logic [6:0] PV = 7'b1100100;
  localparam logic [6:0] NV = 7'b1100000;

  logic clk = 1'b0;
  logic rst_n;
  logic sof, lv, en;
  logic [13:0] pix;
  logic sync_o, lane_lo_o, lane_hi_o, wstrb_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  int m_in = 0, m_lead = 0, m_pos = 0, m_line = 0;
  logic p_sof, p_lv, p_en;
  logic [13:0] p_pix;
  string p_tag;

  always #5 clk = ~clk;

  sync7_video_tx #(
    .PIX_W(14), .LINE_SYMS(LSYM), .ACT_SYMS(ACT), .LINES(NL), .LEAD_SYMS(4)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .lv_i(lv), .en_i(en), .pix_i(pix),
    .sync_o(sync_o), .lane_lo_o(lane_lo_o), .lane_hi_o(lane_hi_o), .wstrb_o(wstrb_o)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {strb,sync,hi,lo} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic s, input logic l, input logic e, input logic [13:0] px,
                       output logic [6:0] es, output logic [6:0] elo, output logic [6:0] ehi);
    es = NV; elo = '0; ehi = '0;
    if (s) begin
      es = FS; m_in = 1; m_lead = 3; m_pos = 0; m_line = 0;
    end else if (m_in != 0 && m_lead > 0) begin
      m_lead--;
    end else if (m_in != 0) begin
      if (l && m_pos < ACT) begin
        es = PV; elo = px[6:0]; ehi = px[13:7];
      end
      m_pos++;
      if (m_pos == LSYM) begin
        m_pos = 0;
        m_line++;
        if (m_line == NL) m_in = 0;
      end
    end
    if (!e) begin
      es = '0; elo = '0; ehi = '0;
    end
  endtask

  // called at the falling edge in a strobe cycle
  task automatic step(input string tag, input logic s, input logic l, input logic e,
                      input logic [13:0] px);
    logic [6:0] es, elo, ehi;
    string ctag;
    model(p_sof, p_lv, p_en, p_pix, es, elo, ehi);
    ctag = {"R2 R3 R11 ", p_tag};
    sof = s; lv = l; en = e; pix = px;
    p_sof = s; p_lv = l; p_en = e; p_pix = px; p_tag = tag;
    for (int i = 0; i < 7; i++) begin
      if (i > 0) @(negedge clk);
      check(ctag, {wstrb_o, sync_o, lane_hi_o, lane_lo_o},
            {(i == 0), es[6-i], ehi[6-i], elo[6-i]});
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sof = 1'b0; lv = 1'b0; en = 1'b1; pix = '0;
    p_sof = 1'b0; p_lv = 1'b0; p_en = 1'b1; p_pix = '0; p_tag = "R1";
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {wstrb_o, sync_o, lane_hi_o, lane_lo_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first strobe", {wstrb_o, 3'b000}, 4'b1000);

    // idle: lv ignored
    step("R8 idle", 0, 1, 1, 14'h1234);
    step("R8 idle", 0, 1, 1, 14'h0F0F);
    // frame start and lead
    step("R6 sof", 1, 1, 1, 14'h0AAA);
    for (int k = 0; k < 3; k++) step("R6 lead", 0, 1, 1, 14'h3333);
    // full frame, lv held high: window and split
    for (int ln = 0; ln < NL; ln++) begin
      for (int ps = 0; ps < LSYM; ps++) begin
        logic [13:0] v;
        v = 14'(ln * 1111 + ps * 523 + 1);
        if (ln == 0 && ps == 0) v = 14'h3FFF;
        if (ln == 0 && ps == 1) v = 14'h2AAA;
        if (ln == 1 && ps == 0) v = 14'h0001;
        if (ln == 1 && ps == 1) v = 14'h2000;
        step("R4 R7", 0, 1, 1, v);
      end
    end
    // frame over
    step("R8 after frame", 0, 1, 1, 14'h1555);
    step("R8 after frame", 0, 1, 1, 14'h2222);
    // second frame with gaps and blanking
    step("R6 sof", 1, 0, 1, 14'h0000);
    for (int k = 0; k < 3; k++) step("R6 lead", 0, 1, 1, 14'h1FFF);
    for (int ps = 0; ps < 5; ps++) begin
      logic e;
      e = !(ps == 2 || ps == 3);
      step(e ? "R5 gap" : "R10 blank", 0, (ps % 2) == 0, e, 14'(ps * 999 + 7));
    end
    // restart mid-line
    step("R9 restart", 1, 1, 1, 14'h3ABC);
    for (int k = 0; k < 3; k++) step("R9 lead", 0, 1, 1, 14'h0123);
    for (int k = 0; k < 4; k++) step("R9 pixels", 0, 1, 1, 14'(k * 3001 + 11));
    step("R10 blank sof", 1, 1, 0, 14'h3FFF);
    step("R10 lead", 0, 1, 1, 14'h0000);
    step("R10 flush", 0, 0, 1, 14'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule